// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block holds the exception bookkeeping that travels beside the instructions of a five-stage pipeline (fetch, decode, execute, memory, write-back). It holds a valid flag, a program counter and a cause code for each instruction in flight. A fault detected in any stage is written into that instruction's entry and carried forward. No action is taken until the instruction reaches write-back. At that point the block commits the exception: it captures the faulting PC and the cause, sends fetch to a fixed vector, and squashes every younger instruction.

An external interrupt enters at fetch. It takes the fetch slot as a faulting no-op whose PC is the fetched address, so the saved PC names the instruction to restart from. Each stage also gets a kill strobe. The surrounding datapath uses it to block register-file and memory writes for an instruction that is being squashed or already carries a fault. The pipeline advances every cycle. There is no stream interface and no back-pressure. All pins are plain control and status wires, and the datapath units themselves lie outside the block.

Top module: `exc_tracker`

## Requirements
- R1: While reset is held and right after it, redirect_o and kill_o are 0, and epc_o and cause_o read 0.
- R2: An instruction fetched in cycle t that carries a fault raises redirect_o in cycle t+4, when it occupies write-back, and in no earlier cycle.
- R3: Cause codes are 1 interrupt, 2 fetch fault, 3 illegal instruction, 4 overflow, 5 data access fault. Code 0 means no exception.
- R4: When one instruction is flagged in several stages, the cause from the earliest stage is kept. Interrupt outranks fetch fault in the fetch stage.
- R5: irq_i together with fetch_valid_i turns the fetched instruction into a faulting no-op with cause 1 and the fetch PC.
- R6: In the cycle after a commit, epc_o holds the committed instruction's PC and cause_o its code. Both hold their value until the next commit.
- R7: While redirect_o is 1, redirect_pc_o equals the VECTOR parameter.
- R8: At commit, kill_o is raised for every valid younger stage. Those instructions are removed and never commit later.
- R9: When several instructions fault, the oldest one commits and the younger faults are discarded.
- R10: kill_o[s] is 1 for a valid instruction in stage s that carries a fault, including one flagged in that same cycle. Bit order: 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back.
- R11: Fault strobes and interrupts that arrive for an empty stage (a bubble) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | An instruction is fetched this cycle |
| fetch_pc_i | input | PC_W | PC of the fetched instruction |
| irq_i | input | 1 | External interrupt request, sampled at fetch |
| fetch_fault_i | input | 1 | Fetch translation fault for the fetched instruction |
| decode_illegal_i | input | 1 | Instruction in decode is illegal |
| exec_ovf_i | input | 1 | Instruction in execute overflowed |
| mem_fault_i | input | 1 | Data access fault for the instruction in memory |
| redirect_o | output | 1 | Exception commits this cycle; fetch must restart at redirect_pc_o |
| redirect_pc_o | output | PC_W | Exception vector address |
| epc_o | output | PC_W | PC of the last committed faulting instruction |
| cause_o | output | 3 | Cause code of the last commit |
| kill_o | output | 5 | Per-stage write suppression / squash |

## Verification
On every cycle, the assertions check that a commit loads the saved PC from the write-back entry, that the saved PC and cause stay fixed between commits, that the committed cause is always one of the five defined codes, that a commit leaves the pipeline empty, and that an interrupt kills its fetch slot. Which instruction wins a race, which cause survives several faults on one instruction, the exact cycle of the redirect, and the effect of strobes on bubbles can only be shown by the bench. It sweeps every fault combination on a single instruction, every pair of single faults on adjacent instructions, faults separated by gaps, and bubbles, and computes every expected value from instruction order and the mask bits.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int STAGES = 5;

  typedef enum logic [2:0] {
    CZ_NONE    = 3'd0,
    CZ_IRQ     = 3'd1,
    CZ_FETCH   = 3'd2,
    CZ_ILLEGAL = 3'd3,
    CZ_OVF     = 3'd4,
    CZ_DATA    = 3'd5
  } cause_e;

  // cause raised by the local strobe of a given stage
  function automatic cause_e stage_cause(input int s);
    case (s)
      0:       return CZ_FETCH;
      1:       return CZ_ILLEGAL;
      2:       return CZ_OVF;
      3:       return CZ_DATA;
      default: return CZ_NONE;
    endcase
  endfunction

  // an earlier cause always survives
  function automatic cause_e keep_first(input cause_e held, input logic hit, input cause_e fresh);
    if (held == CZ_NONE && hit) return fresh;
    return held;
  endfunction
endpackage

// File: rtl/exc_slot.sv
module exc_slot
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic            in_vld_i,
  input  logic [PC_W-1:0] in_pc_i,
  input  cause_e          in_cz_i,
  output logic            out_vld_o,
  output logic [PC_W-1:0] out_pc_o,
  output cause_e          out_cz_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_o <= 1'b0;
      out_pc_o  <= '0;
      out_cz_o  <= CZ_NONE;
    end else if (flush_i) begin
      out_vld_o <= 1'b0;
      out_cz_o  <= CZ_NONE;
    end else begin
      out_vld_o <= in_vld_i;
      out_pc_o  <= in_pc_i;
      out_cz_o  <= in_vld_i ? in_cz_i : CZ_NONE;
    end
  end
endmodule

// File: rtl/exc_commit.sv
module exc_commit
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_i,
  input  logic [PC_W-1:0] pc_i,
  input  cause_e          cz_i,
  output logic [PC_W-1:0] epc_o,
  output logic [2:0]      cause_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_o   <= '0;
      cause_o <= '0;
    end else if (commit_i) begin
      epc_o   <= pc_i;
      cause_o <= cz_i;
    end
  end
endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
  import exc_pkg::*;
#(
  parameter int              PC_W   = 32,
  parameter logic [PC_W-1:0] VECTOR = 'h100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_valid_i,
  input  logic [PC_W-1:0]     fetch_pc_i,
  input  logic                irq_i,
  input  logic                fetch_fault_i,
  input  logic                decode_illegal_i,
  input  logic                exec_ovf_i,
  input  logic                mem_fault_i,
  output logic                redirect_o,
  output logic [PC_W-1:0]     redirect_pc_o,
  output logic [PC_W-1:0]     epc_o,
  output logic [2:0]          cause_o,
  output logic [STAGES-1:0]   kill_o
);
  localparam int NSLOT = STAGES - 1;
  localparam int WB    = STAGES - 1;

  // per-stage view after merging that stage's strobe
  logic            st_vld [STAGES];
  logic [PC_W-1:0] st_pc  [STAGES];
  cause_e          st_cz  [STAGES];

  // pipeline registers between stages
  logic [NSLOT-1:0] slot_vld;
  logic [PC_W-1:0]  slot_pc [NSLOT];
  cause_e           slot_cz [NSLOT];

  logic [NSLOT-1:0] hit;
  logic             commit;

  assign hit = {mem_fault_i, exec_ovf_i, decode_illegal_i, fetch_fault_i};

  // fetch stage: an interrupt replaces the fetched instruction
  assign st_vld[0] = fetch_valid_i;
  assign st_pc[0]  = fetch_pc_i;
  assign st_cz[0]  = !fetch_valid_i ? CZ_NONE :
                     irq_i          ? CZ_IRQ  :
                     keep_first(CZ_NONE, hit[0], stage_cause(0));

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    assign st_vld[g] = slot_vld[g-1];
    assign st_pc[g]  = slot_pc[g-1];
    if (g < NSLOT) begin : g_strobe
      assign st_cz[g] = keep_first(slot_cz[g-1], slot_vld[g-1] & hit[g], stage_cause(g));
    end else begin : g_wb
      assign st_cz[g] = slot_cz[g-1];
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    exc_slot #(.PC_W(PC_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (commit),
      .in_vld_i  (st_vld[g]),
      .in_pc_i   (st_pc[g]),
      .in_cz_i   (st_cz[g]),
      .out_vld_o (slot_vld[g]),
      .out_pc_o  (slot_pc[g]),
      .out_cz_o  (slot_cz[g])
    );
  end

  assign commit = st_vld[WB] && (st_cz[WB] != CZ_NONE);

  for (genvar g = 0; g < NSLOT; g++) begin : g_kill
    assign kill_o[g] = st_vld[g] && (commit || st_cz[g] != CZ_NONE);
  end
  assign kill_o[WB] = commit;

  assign redirect_o    = commit;
  assign redirect_pc_o = VECTOR;

  exc_commit #(.PC_W(PC_W)) u_commit (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .pc_i     (st_pc[WB]),
    .cz_i     (st_cz[WB]),
    .epc_o    (epc_o),
    .cause_o  (cause_o)
  );
endmodule

// File: rtl/exc_tracker_chk.sv
module exc_tracker_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_valid_i,
  input logic            irq_i,
  input logic            redirect_o,
  input logic [PC_W-1:0] epc_o,
  input logic [2:0]      cause_o,
  input logic [4:0]      kill_o,
  input logic [PC_W-1:0] wb_pc,
  input logic [3:0]      slot_vld
);
  a_r6_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> epc_o == $past(wb_pc));

  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |=> $stable(epc_o) && $stable(cause_o));

  a_r3_cause_defined: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> (cause_o >= 3'd1 && cause_o <= 3'd5));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> slot_vld == 4'b0000);

  a_r5_irq_kills_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_i && irq_i) |-> kill_o[0]);
endmodule

bind exc_tracker exc_tracker_chk #(.PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_valid_i (fetch_valid_i),
  .irq_i         (irq_i),
  .redirect_o    (redirect_o),
  .epc_o         (epc_o),
  .cause_o       (cause_o),
  .kill_o        (kill_o),
  .wb_pc         (st_pc[4]),
  .slot_vld      (slot_vld)
);

// File: tb/exc_tracker_bench.sv
module exc_tracker_bench;
  localparam int          PC_W = 32;
  localparam logic [31:0] VEC  = 32'h100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, fetch_valid_i, irq_i, fetch_fault_i, decode_illegal_i, exec_ovf_i, mem_fault_i;
  logic [31:0] fetch_pc_i, redirect_pc_o, epc_o;
  logic        redirect_o;
  logic [2:0]  cause_o;
  logic [4:0]  kill_o;

  exc_tracker #(.PC_W(PC_W), .VECTOR(VEC)) u_exc_tracker (
    .clk(clk), .rst_n(rst_n), .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
    .irq_i(irq_i), .fetch_fault_i(fetch_fault_i), .decode_illegal_i(decode_illegal_i),
    .exec_ovf_i(exec_ovf_i), .mem_fault_i(mem_fault_i), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .epc_o(epc_o), .cause_o(cause_o), .kill_o(kill_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // mask bits: 0 irq, 1 fetch fault, 2 illegal, 3 overflow, 4 data fault
  logic [4:0]  mk [4];
  logic [3:0]  vm;
  logic [31:0] exp_epc = '0;
  logic [2:0]  exp_cz  = '0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int low_bit(input logic [4:0] m);
    for (int b = 0; b < 5; b++) if (m[b]) return b;
    return -1;
  endfunction

  task automatic run_scn(input logic [31:0] base);
    int f = -1;
    for (int k = 0; k < 4; k++) if (f < 0 && vm[k] && mk[k] != 0) f = k;
    for (int c = 0; c < 11; c++) begin
      @(negedge clk);
      fetch_valid_i    = (c < 4) ? vm[c] : 1'b0;
      fetch_pc_i       = base + 32'(4 * c);
      irq_i            = (c < 4) ? mk[c][0] : 1'b0;
      fetch_fault_i    = (c < 4) ? mk[c][1] : 1'b0;
      decode_illegal_i = (c >= 1 && c < 5) ? mk[c-1][2] : 1'b0;
      exec_ovf_i       = (c >= 2 && c < 6) ? mk[c-2][3] : 1'b0;
      mem_fault_i      = (c >= 3 && c < 7) ? mk[c-3][4] : 1'b0;
      #1;
      // R2 R9: only the oldest faulter redirects, exactly at write-back
      chk("R2 R9", "redirect", redirect_o, (f >= 0 && c == f + 4));
      chk("R8", "kill wb", kill_o[4], (f >= 0 && c == f + 4));
      if (redirect_o) chk("R7", "vector", redirect_pc_o, VEC);
      // R10 R8 R11: per-stage kill for each younger stage
      for (int s = 0; s < 4; s++) begin
        int  k = c - s;
        bit  v, alive, flt, e;
        v     = (k >= 0 && k < 4) ? vm[k] : 1'b0;
        alive = !(f >= 0 && k > f && c > f + 4);
        flt   = (k >= 0 && k < 4) ? ((mk[k] & 5'((2 << (s + 1)) - 1)) != 0) : 1'b0;
        e     = v && alive && (flt || (f >= 0 && c == f + 4));
        chk("R10 R8 R11", $sformatf("kill stage %0d cyc %0d", s, c), kill_o[s], e);
      end
      if (f >= 0 && c == f + 5) begin
        chk("R6 R5", "epc", epc_o, base + 32'(4 * f));
        chk("R3 R4", "cause", cause_o, low_bit(mk[f]) + 1);
      end
    end
    if (f >= 0) begin
      exp_epc = base + 32'(4 * f);
      exp_cz  = 3'(low_bit(mk[f]) + 1);
    end
    chk("R6", "epc held", epc_o, exp_epc);
    chk("R6", "cause held", cause_o, exp_cz);
  endtask

  task automatic clr_masks();
    for (int k = 0; k < 4; k++) mk[k] = '0;
  endtask

  initial begin
    rst_n = 0; fetch_valid_i = 0; fetch_pc_i = 0; irq_i = 0; fetch_fault_i = 0;
    decode_illegal_i = 0; exec_ovf_i = 0; mem_fault_i = 0;
    clr_masks(); vm = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "redirect in reset", redirect_o, 0);
    chk("R1", "kill in reset", kill_o, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1", "epc after reset", epc_o, 0);
    chk("R1", "cause after reset", cause_o, 0);
    chk("R1", "redirect after reset", redirect_o, 0);

    // every fault combination on one instruction (R4 R5 R3)
    for (int m = 0; m < 32; m++) begin
      clr_masks(); vm = 4'b0001; mk[0] = 5'(m);
      run_scn(32'h1000 + 32'(m * 64));
    end
    // adjacent pairs with one fault each (R9)
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++) begin
        clr_masks(); vm = 4'b0011; mk[0] = 5'(1 << a); mk[1] = 5'(1 << b);
        run_scn(32'h4000 + 32'((a * 5 + b) * 64));
      end
    // late fault on the oldest, interrupt on a younger one at distance d (R8)
    for (int d = 1; d < 4; d++) begin
      clr_masks(); vm = 4'b1111; mk[0] = 5'b10000; mk[d] = 5'b00001;
      run_scn(32'h8000 + 32'(d * 64));
    end
    // bubbles carrying strobes are ignored (R11)
    clr_masks(); vm = 4'b0101; mk[1] = 5'b11111; mk[2] = 5'b00100; mk[3] = 5'b01000;
    run_scn(32'h9000);
    clr_masks(); vm = 4'b0000; mk[0] = 5'b11111; mk[1] = 5'b10101;
    run_scn(32'h9400);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule